// File: doc/BRIEF.md
# Packed-BCD Difference Unit (Nine's-Complement Method)

This block takes two packed decimal operands, each digit held in its own four-bit nibble, and returns their difference as an unsigned decimal magnitude plus a separate sign flag. The subtrahend is first turned into its nine's complement, digit by digit. That value is added to the minuend through a chain of decimal-corrected digit adders. A carry that leaves the top digit is fed back into the bottom digit as an end-around carry. When no such carry appears, the sum is a negative number held in complement form, so it is complemented a second time to give the magnitude.

A pulse on the valid strobe loads one operand pair. In the default registered build, the result and a one-cycle done pulse appear on the clock edge that samples the strobe. The outputs then hold until the next strobe. Any operand nibble above nine marks the request as malformed: the error flag is raised and the magnitude and sign are forced to zero. A parameter selects a purely combinational build, and another sets the digit count, which defaults to two.

Top module: `bcd_nines_sub`

## Requirements
- R1: Each subtrahend digit d is replaced by 9−d before the add. Bits [7:4] of each operand hold the tens digit and bits [3:0] hold the units digit. For example, 47 − 31 gives magnitude 0x16 with diff_neg = 0.
- R2: A digit position whose sum exceeds 9 is corrected by adding 6, and the resulting carry goes into the next higher digit. For example, 58 − 19 gives +39.
- R3: A carry out of the top digit is added back into the units digit. The result is then positive (diff_neg = 0) and already in true form. For example, 90 − 09 gives +81.
- R4: When the top digit gives no carry, diff_neg = 1 and the magnitude is the nine's complement of the sum. For example, 52 − 67 gives magnitude 0x15 with diff_neg = 1.
- R5: Equal operands give magnitude 0x00 with diff_neg = 0. The complement-form all-nines result is never reported as a negative zero.
- R6: If any nibble of either operand is above 9, then bad_input = 1, diff_mag = 0 and diff_neg = 0. For a valid pair, bad_input = 0.
- R7: At the range ends, 99 − 00 gives +99 and 00 − 99 gives −99. Every output nibble is a decimal digit.
- R8: In the registered build, the results are updated by the clock edge that samples in_valid high. done is high for exactly that one following cycle and is low after reset.
- R9: While in_valid is low, changes on the operand inputs leave diff_mag, diff_neg and bad_input unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe that loads minuend and subtrahend |
| minuend | input | 4*DIGITS | Packed BCD operand that is subtracted from |
| subtrahend | input | 4*DIGITS | Packed BCD operand that is subtracted |
| diff_mag | output | 4*DIGITS | Packed BCD magnitude of the difference |
| diff_neg | output | 1 | 1 when the difference is negative |
| done | output | 1 | One-cycle pulse marking a fresh result |
| bad_input | output | 1 | 1 when the last loaded operand had a nibble above 9 |

## Verification
Every result of the registered build is due one edge after the strobe. This covers magnitude, sign, error flag and done. The bench raises the strobe on a falling edge, lets one rising edge pass, and samples all four outputs a nanosecond later. It then drops the strobe, waits one more rising edge, and confirms that done has fallen while the other outputs are unchanged. Hold behaviour is tested by changing the operands with the strobe low and reading the outputs again after two further edges. Expected values are computed in the bench by plain integer subtraction of the decoded decimal operands.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;
   localparam int DIGIT_W   = 4;
   localparam int DIGIT_MAX = 9;
   localparam int DIGIT_ADJ = 6;

   function automatic logic [DIGIT_W-1:0] nine_minus(input logic [DIGIT_W-1:0] d);
      return DIGIT_W'(DIGIT_MAX) - d;
   endfunction
endpackage

// File: rtl/bcd_digit_check.sv
module bcd_digit_check
   import bcd_sub_pkg::*;
#(
   parameter int DIGITS = 2,
   localparam int W = DIGITS * DIGIT_W
) (
   input  logic [W-1:0] vec,
   output logic         ok
);
   logic [DIGITS-1:0] digit_ok;

   for (genvar g = 0; g < DIGITS; g++) begin : g_dig
      assign digit_ok[g] = (vec[g*DIGIT_W +: DIGIT_W] <= DIGIT_W'(DIGIT_MAX));
   end

   assign ok = &digit_ok;
endmodule

// File: rtl/bcd_nines_comp.sv
module bcd_nines_comp
   import bcd_sub_pkg::*;
#(
   parameter int DIGITS = 2,
   localparam int W = DIGITS * DIGIT_W
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   for (genvar g = 0; g < DIGITS; g++) begin : g_dig
      assign dout[g*DIGIT_W +: DIGIT_W] = nine_minus(din[g*DIGIT_W +: DIGIT_W]);
   end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
   import bcd_sub_pkg::*;
(
   input  logic [DIGIT_W-1:0] a,
   input  logic [DIGIT_W-1:0] b,
   input  logic               cin,
   output logic [DIGIT_W-1:0] sum,
   output logic               cout
);
   logic [DIGIT_W:0] raw;
   logic [DIGIT_W:0] adj;

   always_comb begin
      raw  = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
      adj  = raw + (DIGIT_W+1)'(DIGIT_ADJ);
      cout = (raw > (DIGIT_W+1)'(DIGIT_MAX));
      sum  = cout ? adj[DIGIT_W-1:0] : raw[DIGIT_W-1:0];
   end

   // R2: corrected digit stays decimal for decimal inputs
   always_comb begin
      if (a <= DIGIT_W'(DIGIT_MAX) && b <= DIGIT_W'(DIGIT_MAX))
         assert_digit_decimal_R2: assert (sum <= DIGIT_W'(DIGIT_MAX));
   end
endmodule

// File: rtl/bcd_chain_adder.sv
module bcd_chain_adder
   import bcd_sub_pkg::*;
#(
   parameter int DIGITS = 2,
   localparam int W = DIGITS * DIGIT_W
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [DIGITS:0] carry;

   assign carry[0] = cin;

   for (genvar g = 0; g < DIGITS; g++) begin : g_dig
      bcd_digit_adder u_dig (
         .a   (a[g*DIGIT_W +: DIGIT_W]),
         .b   (b[g*DIGIT_W +: DIGIT_W]),
         .cin (carry[g]),
         .sum (sum[g*DIGIT_W +: DIGIT_W]),
         .cout(carry[g+1])
      );
   end

   assign cout = carry[DIGITS];
endmodule

// File: rtl/bcd_nines_sub.sv
module bcd_nines_sub
   import bcd_sub_pkg::*;
#(
   parameter int DIGITS     = 2,
   parameter bit REGISTERED = 1'b1,
   localparam int W = DIGITS * DIGIT_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] minuend,
   input  logic [W-1:0] subtrahend,
   output logic [W-1:0] diff_mag,
   output logic         diff_neg,
   output logic         done,
   output logic         bad_input
);
   if (DIGITS < 1 || DIGITS > 8) begin : g_bad_param
      $error("bcd_nines_sub: DIGITS must lie in 1..8");
   end

   logic         ok_a, ok_b;
   logic [W-1:0] sub_comp;
   logic [W-1:0] sum_first;
   logic         carry_top;
   logic [W-1:0] sum_wrapped;
   logic         carry_again;
   logic [W-1:0] mag_neg;
   logic [W-1:0] c_mag;
   logic         c_neg;
   logic         c_bad;

   bcd_digit_check #(.DIGITS(DIGITS)) u_chk_a (.vec(minuend),    .ok(ok_a));
   bcd_digit_check #(.DIGITS(DIGITS)) u_chk_b (.vec(subtrahend), .ok(ok_b));

   bcd_nines_comp #(.DIGITS(DIGITS)) u_comp (.din(subtrahend), .dout(sub_comp));

   bcd_chain_adder #(.DIGITS(DIGITS)) u_add_main (
      .a   (minuend),
      .b   (sub_comp),
      .cin (1'b0),
      .sum (sum_first),
      .cout(carry_top)
   );

   // end-around carry pass
   bcd_chain_adder #(.DIGITS(DIGITS)) u_add_wrap (
      .a   (sum_first),
      .b   ('0),
      .cin (carry_top),
      .sum (sum_wrapped),
      .cout(carry_again)
   );

   bcd_nines_comp #(.DIGITS(DIGITS)) u_recomp (.din(sum_first), .dout(mag_neg));

   always_comb begin
      c_bad = !(ok_a && ok_b);
      c_mag = '0;
      c_neg = 1'b0;
      if (!c_bad) begin
         if (carry_top) begin
            c_mag = sum_wrapped;
         end else if (mag_neg != '0) begin
            c_mag = mag_neg;
            c_neg = 1'b1;
         end
      end
   end

   // R3: a wrapped sum can never produce a second carry for decimal operands
   always_comb begin
      if (!c_bad)
         assert_no_second_carry_R3: assert (!carry_again);
   end

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            diff_mag  <= '0;
            diff_neg  <= 1'b0;
            bad_input <= 1'b0;
            done      <= 1'b0;
         end else begin
            done <= in_valid;
            if (in_valid) begin
               diff_mag  <= c_mag;
               diff_neg  <= c_neg;
               bad_input <= c_bad;
            end
         end
      end

      assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         bad_input |-> (diff_mag == '0 && !diff_neg));

      assert_no_negzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
         diff_neg |-> (diff_mag != '0));

      assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !done);

      assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(diff_mag) && $stable(diff_neg) && $stable(bad_input)));

      assert_neg_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(diff_neg) |-> $past(in_valid));
   end else begin : g_comb
      assign diff_mag  = c_mag;
      assign diff_neg  = c_neg;
      assign bad_input = c_bad;
      assign done      = in_valid;
   end
endmodule

// File: tb/test_bcd_nines_sub.sv
module test_bcd_nines_sub;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] minuend = '0;
   logic [7:0] subtrahend = '0;
   logic [7:0] diff_mag;
   logic       diff_neg;
   logic       done;
   logic       bad_input;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bcd_nines_sub i_bcd_nines_sub (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .minuend(minuend), .subtrahend(subtrahend),
      .diff_mag(diff_mag), .diff_neg(diff_neg),
      .done(done), .bad_input(bad_input)
   );

   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic int from_bcd(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // apply one pair, check results one edge later, then done drop
   task automatic run_pair(input string req, input logic [7:0] a, input logic [7:0] b);
      int d;
      bit bad;
      logic [7:0] m_exp;
      bad = (a[7:4] > 9) || (a[3:0] > 9) || (b[7:4] > 9) || (b[3:0] > 9);
      d = from_bcd(a) - from_bcd(b);
      m_exp = bad ? 8'h00 : to_bcd(d < 0 ? -d : d);
      @(negedge clk);
      minuend = a; subtrahend = b; in_valid = 1'b1;
      @(posedge clk); #1;
      check(req, "done", int'(done), 1);
      check(req, "mag", int'(diff_mag), int'(m_exp));
      check(req, "neg", int'(diff_neg), (!bad && d < 0) ? 1 : 0);
      check(req, "bad", int'(bad_input), int'(bad));
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #1;
      check("R8", "done_drop", int'(done), 0);
   endtask

   task automatic t_reset;
      #1;
      check("R8", "reset_done", int'(done), 0);
      check("R6", "reset_bad", int'(bad_input), 0);
      check("R8", "reset_mag", int'(diff_mag), 0);
   endtask

   task automatic t_examples;
      run_pair("R1", 8'h47, 8'h31);
      run_pair("R4", 8'h52, 8'h67);
      run_pair("R2", 8'h58, 8'h19);
      run_pair("R3", 8'h90, 8'h09);
      run_pair("R4", 8'h09, 8'h90);
   endtask

   task automatic t_equal;
      run_pair("R5", 8'h37, 8'h37);
      run_pair("R5", 8'h00, 8'h00);
      run_pair("R5", 8'h99, 8'h99);
   endtask

   task automatic t_extremes;
      run_pair("R7", 8'h99, 8'h00);
      run_pair("R7", 8'h00, 8'h99);
      run_pair("R7", 8'h10, 8'h01);
   endtask

   task automatic t_invalid;
      run_pair("R6", 8'h3A, 8'h12);
      run_pair("R6", 8'h12, 8'hF0);
      run_pair("R6", 8'h45, 8'h23);
   endtask

   task automatic t_hold;
      run_pair("R9", 8'h20, 8'h75);
      @(negedge clk);
      minuend = 8'h88; subtrahend = 8'hAB;
      @(posedge clk); @(posedge clk); #1;
      check("R9", "hold_mag", int'(diff_mag), 'h55);
      check("R9", "hold_neg", int'(diff_neg), 1);
      check("R9", "hold_bad", int'(bad_input), 0);
      check("R9", "hold_done", int'(done), 0);
   endtask

   task automatic t_sweep;
      for (int a = 0; a < 100; a += 7) begin
         for (int b = 0; b < 100; b += 11) begin
            run_pair("R1", to_bcd(a), to_bcd(b));
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset;
      @(negedge clk);
      rst_n = 1'b1;
      t_examples;
      t_equal;
      t_extremes;
      t_invalid;
      t_hold;
      t_sweep;
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule